// File: doc/BRIEF.md
# Queue Interrupt Status and Masking Unit

This block gathers the interrupt conditions of a programmed-I/O queue interface and turns them into one interrupt line. Five condition inputs are levels (data thresholds and queue-ready indications) that the status register simply mirrors. The rest are one-cycle event pulses for transfer errors, latency warnings and programming errors. Once recorded, these stay set until software clears them.

Software sees four 32-bit registers on a simple write/read port. A status-enable register decides which conditions may reach the status register at all. A signal-enable register decides which recorded status bits drive the interrupt line. Status bits are cleared by writing 1 to them. A force register lets software plant any sticky bit for test or recovery. The queue logic that produces the conditions sits outside this block.

Top module: `queue_irq_unit`

## Requirements
- R1: After reset, the status (byte offset 0x20), status-enable (0x24) and signal-enable (0x28) registers read zero and `irq_o` is low.
- R2: Writing the status-enable or signal-enable register stores the written value restricted to the implemented positions (0-5, 7, 9, 12-25), and a read at its offset returns it from the next cycle.
- R3: Status bits 0-4 equal, one cycle later, the matching `cond_i` level ANDed with its status-enable bit. Writes to the status register leave them unchanged.
- R4: A sticky bit (positions 5, 7, 9, 12-25) is set in the cycle after its `cond_i` pulse, provided its status-enable bit is 1. It then stays set while its condition is idle.
- R5: Writing 1 to a sticky position of the status register clears that bit in the next cycle. Writing 0 leaves it unchanged.
- R6: When a set (condition or force) and a clearing write reach the same sticky bit in the same cycle, the bit ends up set.
- R7: A condition pulse on a bit whose status-enable bit is 0 leaves the status bit at 0.
- R8: Writing 1 to a position of the force register (0x2c) sets that sticky status bit in the next cycle. This happens whatever the condition input and the status-enable bit are. The force write has no effect on bits 0-4, and the force register always reads 0.
- R9: `irq_o` is high exactly when some status bit and the same signal-enable bit are both 1. It changes in the same cycle the register contents change.
- R10: Unimplemented positions (6, 8, 10, 11, 26-31) read 0 in every register and never become set.
- R11: Writes to any other address change no register, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address for writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| cond_i | input | 32 | Condition inputs: levels on bits 0-4, event pulses elsewhere |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: 8-bit addressing and the combinational interrupt output. With these settings `irq_o` and `rdata_o` can be compared against a behavioural model in the same cycle that a register changes. Directed sequences reach the set-versus-clear collision, forcing with the enables off, and status-enable gating of a single bit. After those, a random phase mixes writes to all four offsets, stray addresses and random condition vectors. That phase drives both register kinds through every mix of set, clear and gating.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned DATA_W = 32;

   localparam logic [7:0] OFS_STATUS = 8'h20;
   localparam logic [7:0] OFS_ST_EN  = 8'h24;
   localparam logic [7:0] OFS_SIG_EN = 8'h28;
   localparam logic [7:0] OFS_FORCE  = 8'h2c;

   localparam int unsigned NUM_LEVEL = 5;
   localparam logic [DATA_W-1:0] LEVEL_MASK  = (DATA_W'(1) << NUM_LEVEL) - DATA_W'(1);
   localparam logic [DATA_W-1:0] STICKY_MASK = 32'h03FF_F2A0;
   localparam logic [DATA_W-1:0] IMPL_MASK   = LEVEL_MASK | STICKY_MASK;

   typedef enum logic [1:0] {
      CK_NONE   = 2'd0,
      CK_LEVEL  = 2'd1,
      CK_STICKY = 2'd2
   } cell_kind_e;

   function automatic cell_kind_e kind_of(input int b);
      if (LEVEL_MASK[b])       return CK_LEVEL;
      else if (STICKY_MASK[b]) return CK_STICKY;
      else                     return CK_NONE;
   endfunction
endpackage

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
   parameter int unsigned        W    = 32,
   parameter logic [W-1:0]       MASK = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   q_o <= '0;
      else if (we_i) q_o <= d_i & MASK;
   end
endmodule

// File: rtl/irq_stat_cell.sv
module irq_stat_cell #(
   parameter irq_pkg::cell_kind_e KIND = irq_pkg::CK_NONE
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic en_i,
   input  logic cond_i,
   input  logic force_i,
   input  logic clr_i,
   output logic q_o
);
   if (KIND == irq_pkg::CK_LEVEL) begin : g_level
      logic unused_lvl;
      assign unused_lvl = force_i ^ clr_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) q_o <= 1'b0;
         else         q_o <= cond_i & en_i;
      end
      a_r3_level_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(cond_i & en_i) |=> q_o);
   end else if (KIND == irq_pkg::CK_STICKY) begin : g_sticky
      logic set_w;
      assign set_w = (cond_i & en_i) | force_i;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    q_o <= 1'b0;
         else if (set_w) q_o <= 1'b1;
         else if (clr_i) q_o <= 1'b0;
      end
      a_r4_sticky_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (q_o && !clr_i) |=> q_o);
      a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (force_i && clr_i) |=> q_o);
   end else begin : g_none
      logic unused_none;
      assign unused_none = ^{clk_i, rst_ni, en_i, cond_i, force_i, clr_i};
      assign q_o = 1'b0;
   end
endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux #(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned W      = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [W-1:0]      stat_i,
   input  logic [W-1:0]      sten_i,
   input  logic [W-1:0]      sig_i,
   output logic [W-1:0]      rdata_o
);
   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(irq_pkg::OFS_STATUS))      rdata_o = stat_i;
      else if (addr_i == ADDR_W'(irq_pkg::OFS_ST_EN))  rdata_o = sten_i;
      else if (addr_i == ADDR_W'(irq_pkg::OFS_SIG_EN)) rdata_o = sig_i;
   end
endmodule

// File: rtl/queue_irq_unit.sv
module queue_irq_unit #(
   parameter int unsigned ADDR_W   = 8,
   parameter bit          IRQ_FLOP = 1'b0
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       wr_en_i,
   input  logic [ADDR_W-1:0]          addr_i,
   input  logic [irq_pkg::DATA_W-1:0] wdata_i,
   output logic [irq_pkg::DATA_W-1:0] rdata_o,
   input  logic [irq_pkg::DATA_W-1:0] cond_i,
   output logic                       irq_o
);
   localparam int unsigned DW = irq_pkg::DATA_W;

   initial begin
      if (ADDR_W < 6) $error("queue_irq_unit: ADDR_W too small for register offsets");
   end

   logic wr_stat, wr_sten, wr_sig, wr_force;
   assign wr_stat  = wr_en_i && (addr_i == ADDR_W'(irq_pkg::OFS_STATUS));
   assign wr_sten  = wr_en_i && (addr_i == ADDR_W'(irq_pkg::OFS_ST_EN));
   assign wr_sig   = wr_en_i && (addr_i == ADDR_W'(irq_pkg::OFS_SIG_EN));
   assign wr_force = wr_en_i && (addr_i == ADDR_W'(irq_pkg::OFS_FORCE));

   logic [DW-1:0] sten_q, sig_q, stat_q;
   logic [DW-1:0] force_v, clr_v;
   assign force_v = wr_force ? wdata_i : '0;
   assign clr_v   = wr_stat  ? wdata_i : '0;

   irq_cfg_reg #(.W(DW), .MASK(irq_pkg::IMPL_MASK)) u_sten (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_sten), .d_i(wdata_i), .q_o(sten_q));
   irq_cfg_reg #(.W(DW), .MASK(irq_pkg::IMPL_MASK)) u_sig (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_sig), .d_i(wdata_i), .q_o(sig_q));

   for (genvar b = 0; b < DW; b++) begin : g_bit
      irq_stat_cell #(.KIND(irq_pkg::kind_of(b))) u_cell (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (sten_q[b]),
         .cond_i (cond_i[b]),
         .force_i(force_v[b]),
         .clr_i  (clr_v[b]),
         .q_o    (stat_q[b]));
   end

   irq_rd_mux #(.ADDR_W(ADDR_W), .W(DW)) u_rd (
      .addr_i(addr_i), .stat_i(stat_q), .sten_i(sten_q), .sig_i(sig_q), .rdata_o(rdata_o));

   logic irq_next;
   assign irq_next = |(stat_q & sig_q);

   if (IRQ_FLOP) begin : g_irq_flop
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) irq_o <= 1'b0;
         else         irq_o <= irq_next;
      end
   end else begin : g_irq_comb
      assign irq_o = irq_next;
      a_r9_irq_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (sig_q == '0) |-> !irq_o);
   end

   a_r8_force_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i == ADDR_W'(irq_pkg::OFS_FORCE)) |-> (rdata_o == '0));
   a_r10_unimpl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_force |=> ((stat_q & ~irq_pkg::IMPL_MASK) == '0));
endmodule

// File: tb/test_queue_irq_unit.sv
module test_queue_irq_unit;
   localparam logic [31:0] IMPL = 32'h03FF_F2BF;
   localparam logic [31:0] LVL  = 32'h0000_001F;
   localparam logic [31:0] STK  = IMPL & ~LVL;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] cond = '0;
   logic [31:0] rdata;
   logic        irq;

   always #2 clk = ~clk;

   queue_irq_unit i_queue_irq_unit (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .cond_i(cond), .irq_o(irq));

   int n_chk = 0;
   int n_bad = 0;
   logic [31:0] m_stat = '0, m_sten = '0, m_sig = '0;

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h20:   return m_stat;
         8'h24:   return m_sten;
         8'h28:   return m_sig;
         default: return 32'h0;
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [31:0] er;
      logic        ei;
      er = exp_read(addr);
      ei = |(m_stat & m_sig);
      n_chk++;
      if (rdata !== er) begin
         n_bad++;
         $display("FAIL %s rdata @%h: actual %h expected %h", tag, addr, rdata, er);
      end
      n_chk++;
      if (irq !== ei) begin
         n_bad++;
         $display("FAIL %s irq: actual %b expected %b", tag, irq, ei);
      end
   endtask

   task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d,
                       input logic [31:0] c, input string tag);
      logic [31:0] set_v, clr_v;
      wr_en = w; addr = a; wdata = d; cond = c;
      @(posedge clk);
      set_v = (c & m_sten) | ((w && a == 8'h2c) ? d : 32'h0);
      clr_v = (w && a == 8'h20) ? d : 32'h0;
      m_stat = (c & m_sten & LVL) | (STK & (set_v | (m_stat & ~clr_v)));
      if (w && a == 8'h24) m_sten = d & IMPL;
      if (w && a == 8'h28) m_sig  = d & IMPL;
      @(negedge clk);
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      addr = 8'h20;
      compare("R1");
      rst_n = 1'b1;
      step(0, 8'h20, 0, 0, "R1");
      step(0, 8'h24, 0, 0, "R1");
      step(0, 8'h28, 0, 0, "R1");
      step(0, 8'h2c, 0, 0, "R1");
      // R2 enable registers
      step(1, 8'h24, 32'hFFFF_FFFF, 0, "R2");
      step(1, 8'h28, 32'hA5A5_5A5A, 0, "R2");
      step(1, 8'h28, 32'h0, 0, "R2");
      // R3 level bits
      step(0, 8'h20, 0, 32'h1F, "R3");
      step(1, 8'h20, 32'h1F, 32'h1F, "R3");
      step(0, 8'h20, 0, 32'h05, "R3");
      step(0, 8'h20, 0, 0, "R3");
      // R4 sticky
      step(0, 8'h20, 0, 32'h1 << 13, "R4");
      step(0, 8'h20, 0, 0, "R4");
      // R5 clear
      step(1, 8'h20, ~(32'h1 << 13), 0, "R5");
      step(1, 8'h20, 32'h1 << 13, 0, "R5");
      // R6 set beats clear
      step(1, 8'h20, 32'h1 << 20, 32'h1 << 20, "R6");
      step(0, 8'h20, 0, 0, "R6");
      // R7 gating
      step(1, 8'h24, ~(32'h1 << 9), 0, "R7");
      step(0, 8'h20, 0, 32'h1 << 9, "R7");
      step(0, 8'h20, 0, 0, "R7");
      // R8 force
      step(1, 8'h24, 0, 0, "R8");
      step(1, 8'h2c, 32'hFFFF_FFFF, 0, "R8");
      step(0, 8'h20, 0, 0, "R8");
      step(1, 8'h20, 32'hFFFF_FFFF, 0, "R5");
      // R9 interrupt
      step(1, 8'h24, 32'hFFFF_FFFF, 0, "R9");
      step(1, 8'h28, 32'h1 << 17, 0, "R9");
      step(0, 8'h20, 0, 32'h1 << 16, "R9");
      step(0, 8'h20, 0, 32'h1 << 17, "R9");
      step(1, 8'h20, 32'h1 << 17, 0, "R9");
      step(1, 8'h28, 32'h1 << 1, 0, "R9");
      step(0, 8'h28, 0, 32'h1 << 1, "R9");
      step(0, 8'h28, 0, 0, "R9");
      // R10 unimplemented positions
      step(0, 8'h20, 0, 32'hFFFF_FFFF, "R10");
      step(1, 8'h2c, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R10");
      step(0, 8'h20, 0, 0, "R10");
      step(1, 8'h24, 32'hFFFF_FFFF, 0, "R10");
      step(1, 8'h20, 32'hFFFF_FFFF, 0, "R10");
      // R11 other addresses
      step(1, 8'h30, 32'hFFFF_FFFF, 0, "R11");
      step(1, 8'h21, 32'hFFFF_FFFF, 0, "R11");
      step(1, 8'h00, 32'h0, 0, "R11");
      step(0, 8'h24, 0, 0, "R11");
      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [7:0] ra;
         logic [31:0] rc;
         case ($urandom_range(0, 5))
            0: ra = 8'h20;
            1: ra = 8'h24;
            2: ra = 8'h28;
            3: ra = 8'h2c;
            4: ra = 8'h30;
            default: ra = 8'h1c;
         endcase
         rc = $urandom() & $urandom();
         step(logic'($urandom_range(0, 2) == 0), ra, $urandom(), rc, "R4");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule